// File: doc/BRIEF.md
# Slot Mailbox with Doorbell and Status Registers

This block is a one-way mailbox between a host and an embedded engine. The host pushes 32-bit slots into a circular store through a write window. The engine pops them, oldest first, through a read window. Each side reaches the block through its own simple register bus, made of a select, a write enable, an address, write data and registered read data. Each side has a control and status register. It carries an interrupt enable, an interrupt status, a doorbell trigger, a ready flag and a reset request. It also shows the shared read offset, the shared write offset and the buffer depth, in fixed bit positions.

The two offsets are free-running 8-bit counters. Software works out the fill count by subtracting them in 8-bit arithmetic, and the free count as the depth minus the fill. A side rings the other side by writing 1 to its doorbell bit. This sets the other side's interrupt status, which that side clears by writing 1. Slots move only while both sides are ready. Either reset request clears both offsets and holds both ready flags low.

The register buses carry no back-pressure. Every selected access completes in the cycle it is presented and is never stalled. Read data appears on the side's read-data port in the cycle after the read. A push that cannot be taken is dropped. A pop that finds nothing returns zero. Software discovers both from the offsets and the overflow flag, and is expected to check the free count before pushing and the fill count before popping.

Top module: `mbx_mailbox`

## Requirements
- R1: A host write to offset 0x0 while the link is up and the buffer is not full stores the slot and advances the write offset by one. An engine read of offset 0x8 returns slots in the order they were written and advances the read offset by one.
- R2: Both status registers share one layout. Bit 0 is interrupt enable, bit 1 interrupt status, bit 2 doorbell (always reads 0), bit 3 ready and bit 4 reset request. Bit 5 is overflow on the host register and reads 0 on the engine register. Bits 15:8 hold the read offset, bits 23:16 the write offset and bits 31:24 the depth in slots. The host register sits at 0x4 and the engine register at 0xC, and both sides can read both.
- R3: The offsets count modulo 256 and index storage with their low bits. The fill count (write offset minus read offset, modulo 256) never exceeds the depth, and the free count is the depth minus the fill. This stays correct when the write offset has wrapped past 255 and the read offset has not.
- R4: A push while the buffer is full is dropped and leaves the write offset unchanged. It sets the sticky host overflow bit (bit 5), which stays set until the host writes 1 to that bit.
- R5: A pop while the buffer is empty returns 0 and leaves the read offset unchanged.
- R6: Writing 1 to the doorbell bit of a side's own register sets the other side's interrupt status. Each interrupt output is high exactly while that side's enable and status bits are both 1.
- R7: Writing 1 to the interrupt status bit clears it, and writing 0 leaves it unchanged.
- R8: Slots move only while both ready bits are 1. Otherwise a push is dropped without setting overflow, and a pop returns 0 and leaves the read offset unchanged.
- R9: While either reset request bit is 1, both offsets are forced to 0 and both ready bits are forced to 0, and a write setting ready is ignored. Ready can be set again once both requests are 0.
- R10: After the active-low reset, both offsets and all control bits are 0, the depth field equals the DEPTH parameter, and both interrupts are low.
- R11: Writes to the other side's status register are ignored. A host read of offset 0x8 returns 0 and pops nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_sel | input | 1 | Host access strobe |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | ADDR_W | Host byte offset |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, valid the cycle after a read |
| e_sel | input | 1 | Engine access strobe |
| e_we | input | 1 | Engine write (1) or read (0) |
| e_addr | input | ADDR_W | Engine byte offset |
| e_wdata | input | 32 | Engine write data |
| e_rdata | output | 32 | Engine read data, valid the cycle after a read |
| h_irq | output | 1 | Host interrupt |
| e_irq | output | 1 | Engine interrupt |

## Verification
The bench fills the buffer to exactly the depth and pushes once more. A design with an off-by-one full test would either lose the last legal slot or overwrite the oldest one, and the popped order would show it. It also runs the offsets through 255 until the write offset has wrapped while the read offset has not. A design that compares offsets without wrapping would report a huge fill or block the producer there. Reads of an empty buffer and accesses while a ready bit is low must leave the offsets untouched. The reset request is driven while the other side tries to raise ready, which exposes a design that lets ready come back too early or that clears offsets without dropping ready.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned SLOT_W = 32;
  localparam int unsigned OFF_W  = 8;

  // byte offsets of the four windows
  localparam logic [3:0] OFS_PUSH  = 4'h0;
  localparam logic [3:0] OFS_HSTAT = 4'h4;
  localparam logic [3:0] OFS_POP   = 4'h8;
  localparam logic [3:0] OFS_ESTAT = 4'hC;

  // control bit positions inside a status word
  localparam int unsigned B_IE  = 0;
  localparam int unsigned B_IS  = 1;
  localparam int unsigned B_DB  = 2;
  localparam int unsigned B_RDY = 3;
  localparam int unsigned B_RST = 4;
  localparam int unsigned B_OVF = 5;

  typedef struct packed {
    logic [7:0] depth;
    logic [7:0] wr;
    logic [7:0] rd;
    logic [1:0] rsv;
    logic       ovf;
    logic       rst;
    logic       rdy;
    logic       db;
    logic       is;
    logic       ie;
  } stat_word_t;
endpackage

// File: rtl/mbx_ring.sv
module mbx_ring
  import mbx_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [SLOT_W-1:0] push_data,
  input  logic              pop,
  output logic [SLOT_W-1:0] pop_data,
  output logic [OFF_W-1:0]  wr_off,
  output logic [OFF_W-1:0]  rd_off,
  output logic              full,
  output logic              empty,
  output logic              push_drop
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [OFF_W-1:0] DEPTH_B = OFF_W'(DEPTH);

  logic [SLOT_W-1:0] store [DEPTH];
  logic [OFF_W-1:0]  wr_q, rd_q, fill;
  logic              push_ok, pop_ok;

  assign fill      = wr_q - rd_q;
  assign full      = (fill == DEPTH_B);
  assign empty     = (fill == '0);
  assign push_ok   = push && !full && !clr;
  assign pop_ok    = pop && !empty && !clr;
  assign push_drop = push && full && !clr;
  assign pop_data  = empty ? '0 : store[rd_q[IDX_W-1:0]];
  assign wr_off    = wr_q;
  assign rd_off    = rd_q;

  always_ff @(posedge clk) begin
    if (push_ok) store[wr_q[IDX_W-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (push_ok) wr_q <= wr_q + 1'b1;
      if (pop_ok)  rd_q <= rd_q + 1'b1;
    end
  end

  // R3
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q - rd_q) <= DEPTH_B);
  // R4
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !clr) |=> $stable(wr_q));
  // R5
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !clr) |=> $stable(rd_q));
  // R9
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (wr_q == '0 && rd_q == '0));
endmodule

// File: rtl/mbx_side_ctl.sv
module mbx_side_ctl
  import mbx_pkg::*;
#(
  parameter bit HAS_OVF = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wdata,
  input  logic              db_in,
  input  logic              other_rst,
  input  logic              ovf_set,
  output logic              ie,
  output logic              is,
  output logic              rdy,
  output logic              rst_req,
  output logic              ovf,
  output logic              db_out,
  output logic              irq
);
  logic ie_q, is_q, rdy_q, rst_q;

  assign db_out = wr_en && wdata[B_DB];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      is_q  <= 1'b0;
      rdy_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      if (wr_en) begin
        ie_q  <= wdata[B_IE];
        rst_q <= wdata[B_RST];
        rdy_q <= wdata[B_RDY] && !wdata[B_RST] && !other_rst;
      end else if (rst_q || other_rst) begin
        rdy_q <= 1'b0;
      end
      if (db_in)                          is_q <= 1'b1;
      else if (wr_en && wdata[B_IS])      is_q <= 1'b0;
    end
  end

  generate
    if (HAS_OVF) begin : g_ovf
      logic ovf_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                       ovf_q <= 1'b0;
        else if (ovf_set)                 ovf_q <= 1'b1;
        else if (wr_en && wdata[B_OVF])   ovf_q <= 1'b0;
      end
      assign ovf = ovf_q;
      // R4
      ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !(wr_en && wdata[B_OVF])) |=> ovf_q);
    end else begin : g_no_ovf
      assign ovf = 1'b0;
    end
  endgenerate

  assign ie      = ie_q;
  assign is      = is_q;
  assign rdy     = rdy_q;
  assign rst_req = rst_q;
  assign irq     = ie_q && is_q;

  // R7
  is_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[B_IS] && !db_in) |=> !is_q);
  // R9
  rdy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    other_rst |=> !rdy_q);
  // R6
  db_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    db_in |=> is_q);
endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_sel,
  input  logic              h_we,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [31:0]       h_wdata,
  output logic [31:0]       h_rdata,
  input  logic              e_sel,
  input  logic              e_we,
  input  logic [ADDR_W-1:0] e_addr,
  input  logic [31:0]       e_wdata,
  output logic [31:0]       e_rdata,
  output logic              h_irq,
  output logic              e_irq
);
  localparam logic [7:0] DEPTH_B = 8'(DEPTH);
  localparam logic [ADDR_W-1:0] A_PUSH  = ADDR_W'(OFS_PUSH);
  localparam logic [ADDR_W-1:0] A_HSTAT = ADDR_W'(OFS_HSTAT);
  localparam logic [ADDR_W-1:0] A_POP   = ADDR_W'(OFS_POP);
  localparam logic [ADDR_W-1:0] A_ESTAT = ADDR_W'(OFS_ESTAT);

  logic h_wr, h_rd, e_wr, e_rd;
  logic link_up, rst_any, push, pop, push_drop, full, empty;
  logic h_ie, h_is, h_rdy, h_rst, h_ovf, h_db;
  logic e_ie, e_is, e_rdy, e_rst, e_ovf, e_db;
  logic [SLOT_W-1:0] pop_data;
  logic [OFF_W-1:0]  wr_off, rd_off;
  stat_word_t h_view, e_view;
  logic [31:0] h_mux, e_mux;

  assign h_wr    = h_sel && h_we;
  assign h_rd    = h_sel && !h_we;
  assign e_wr    = e_sel && e_we;
  assign e_rd    = e_sel && !e_we;
  assign link_up = h_rdy && e_rdy;
  assign rst_any = h_rst || e_rst;
  assign push    = h_wr && (h_addr == A_PUSH) && link_up;
  assign pop     = e_rd && (e_addr == A_POP) && link_up;

  mbx_ring #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .clr(rst_any),
    .push(push), .push_data(h_wdata), .pop(pop), .pop_data(pop_data),
    .wr_off(wr_off), .rd_off(rd_off), .full(full), .empty(empty),
    .push_drop(push_drop)
  );

  mbx_side_ctl #(.HAS_OVF(1'b1)) u_host_ctl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(h_wr && (h_addr == A_HSTAT)), .wdata(h_wdata),
    .db_in(e_db), .other_rst(e_rst), .ovf_set(push_drop),
    .ie(h_ie), .is(h_is), .rdy(h_rdy), .rst_req(h_rst), .ovf(h_ovf),
    .db_out(h_db), .irq(h_irq)
  );

  mbx_side_ctl #(.HAS_OVF(1'b0)) u_eng_ctl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(e_wr && (e_addr == A_ESTAT)), .wdata(e_wdata),
    .db_in(h_db), .other_rst(h_rst), .ovf_set(1'b0),
    .ie(e_ie), .is(e_is), .rdy(e_rdy), .rst_req(e_rst), .ovf(e_ovf),
    .db_out(e_db), .irq(e_irq)
  );

  always_comb begin
    h_view = '{depth: DEPTH_B, wr: wr_off, rd: rd_off, rsv: 2'b00,
               ovf: h_ovf, rst: h_rst, rdy: h_rdy, db: 1'b0, is: h_is, ie: h_ie};
    e_view = '{depth: DEPTH_B, wr: wr_off, rd: rd_off, rsv: 2'b00,
               ovf: e_ovf, rst: e_rst, rdy: e_rdy, db: 1'b0, is: e_is, ie: e_ie};
  end

  always_comb begin
    h_mux = '0;
    if (h_addr == A_HSTAT)      h_mux = h_view;
    else if (h_addr == A_ESTAT) h_mux = e_view;
  end

  always_comb begin
    e_mux = '0;
    if (e_addr == A_HSTAT)      e_mux = h_view;
    else if (e_addr == A_ESTAT) e_mux = e_view;
    else if (e_addr == A_POP)   e_mux = link_up ? pop_data : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_rdata <= '0;
      e_rdata <= '0;
    end else begin
      if (h_rd) h_rdata <= h_mux;
      if (e_rd) e_rdata <= e_mux;
    end
  end

  // R8
  link_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == A_PUSH && !link_up && !rst_any) |=> $stable(wr_off));
  // R8
  link_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (e_rd && e_addr == A_POP && !link_up) |=> (e_rdata == '0));
  // R6
  irq_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_db |=> (e_is && (e_irq == e_ie)));
endmodule

// File: tb/mbx_mailbox_bench.sv
`timescale 1ns/1ps
module mbx_mailbox_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_sel = 0, h_we = 0, e_sel = 0, e_we = 0;
  logic [3:0] h_addr = 0, e_addr = 0;
  logic [31:0] h_wdata = 0, e_wdata = 0;
  logic [31:0] h_rdata, e_rdata;
  logic h_irq, e_irq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mbx_mailbox #(.DEPTH(8), .ADDR_W(4)) u_mbx_mailbox (
    .clk(clk), .rst_n(rst_n),
    .h_sel(h_sel), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .e_sel(e_sel), .e_we(e_we), .e_addr(e_addr), .e_wdata(e_wdata), .e_rdata(e_rdata),
    .h_irq(h_irq), .e_irq(e_irq)
  );

  typedef struct packed {
    logic        side;   // 0 host, 1 engine
    logic        we;
    logic [3:0]  addr;
    logic [31:0] wd;
    logic        chk;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b1, 4'hC, 32'h08, 1'b0, 32'h0, 8'd8},           // engine ready
    '{1'b0, 1'b1, 4'h4, 32'h08, 1'b0, 32'h0, 8'd8},           // host ready
    '{1'b0, 1'b0, 4'h4, 32'h0,  1'b1, 32'h0800_0008, 8'd2},   // R2 layout
    '{1'b0, 1'b1, 4'h0, 32'hA1, 1'b0, 32'h0, 8'd1},
    '{1'b0, 1'b1, 4'h0, 32'hA2, 1'b0, 32'h0, 8'd1},
    '{1'b0, 1'b1, 4'h0, 32'hA3, 1'b0, 32'h0, 8'd1},
    '{1'b0, 1'b0, 4'h4, 32'h0,  1'b1, 32'h0803_0008, 8'd1},   // R1 wr=3
    '{1'b1, 1'b0, 4'h8, 32'h0,  1'b1, 32'hA1, 8'd1},
    '{1'b1, 1'b0, 4'h8, 32'h0,  1'b1, 32'hA2, 8'd1},
    '{1'b1, 1'b0, 4'hC, 32'h0,  1'b1, 32'h0803_0208, 8'd2},
    '{1'b1, 1'b0, 4'h8, 32'h0,  1'b1, 32'hA3, 8'd1},
    '{1'b1, 1'b0, 4'h8, 32'h0,  1'b1, 32'h0, 8'd5},           // R5 empty pop
    '{1'b1, 1'b0, 4'hC, 32'h0,  1'b1, 32'h0803_0308, 8'd5},
    '{1'b0, 1'b1, 4'h4, 32'h0C, 1'b0, 32'h0, 8'd6},           // host doorbell
    '{1'b1, 1'b0, 4'hC, 32'h0,  1'b1, 32'h0803_030A, 8'd6},   // R6
    '{1'b1, 1'b1, 4'hC, 32'h0B, 1'b0, 32'h0, 8'd7},
    '{1'b1, 1'b0, 4'hC, 32'h0,  1'b1, 32'h0803_0309, 8'd7},   // R7
    '{1'b0, 1'b1, 4'hC, 32'h10, 1'b0, 32'h0, 8'd11},          // foreign write
    '{1'b1, 1'b0, 4'hC, 32'h0,  1'b1, 32'h0803_0309, 8'd11},  // R11
    '{1'b0, 1'b1, 4'h0, 32'h55, 1'b0, 32'h0, 8'd1},
    '{1'b0, 1'b0, 4'h8, 32'h0,  1'b1, 32'h0, 8'd11},          // R11 host pop window
    '{1'b1, 1'b0, 4'h8, 32'h0,  1'b1, 32'h55, 8'd11}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic op(input logic side, input logic we, input logic [3:0] addr,
                    input logic [31:0] wd, output logic [31:0] rd);
    if (side) begin e_sel = 1; e_we = we; e_addr = addr; e_wdata = wd; end
    else      begin h_sel = 1; h_we = we; h_addr = addr; h_wdata = wd; end
    @(posedge clk);
    @(negedge clk);
    h_sel = 0; e_sel = 0;
    rd = side ? e_rdata : h_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hw(input logic [3:0] a, input logic [31:0] d);
    logic [31:0] r; op(1'b0, 1'b1, a, d, r);
  endtask
  task automatic ew(input logic [3:0] a, input logic [31:0] d);
    logic [31:0] r; op(1'b1, 1'b1, a, d, r);
  endtask
  task automatic hr(input logic [3:0] a, output logic [31:0] r);
    op(1'b0, 1'b0, a, 32'h0, r);
  endtask
  task automatic er(input logic [3:0] a, output logic [31:0] r);
    op(1'b1, 1'b0, a, 32'h0, r);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%08h expected=%08h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    idle(3);
    @(negedge clk) rst_n = 1;
    // R10 reset state
    check(h_irq == 0 && e_irq == 0, "R10 irq", {h_irq, e_irq}, 0);
    hr(4'h4, r); check(r == 32'h0800_0000, "R10 host stat", r, 32'h0800_0000);
    er(4'h4, r); check(r == 32'h0800_0000, "R10 view", r, 32'h0800_0000);

    for (int i = 0; i < NV; i++) begin
      op(TBL[i].side, TBL[i].we, TBL[i].addr, TBL[i].wd, r);
      if (TBL[i].chk)
        check(r == TBL[i].exp, $sformatf("R%0d table step %0d", TBL[i].req, i), r, TBL[i].exp);
    end

    // R6 doorbell to engine, R7 clear
    check(e_irq == 0, "R6 e_irq idle", e_irq, 0);
    hw(4'h4, 32'h0C);
    check(e_irq == 1, "R6 e_irq raised", e_irq, 1);
    ew(4'hC, 32'h0B);
    check(e_irq == 0, "R7 e_irq cleared", e_irq, 0);
    // R6 doorbell to host
    hw(4'h4, 32'h09);
    ew(4'hC, 32'h0D);
    check(h_irq == 1, "R6 h_irq raised", h_irq, 1);
    hr(4'h4, r); check(r == 32'h0804_040B, "R6 host stat", r, 32'h0804_040B);
    hw(4'h4, 32'h0B);
    check(h_irq == 0, "R7 h_irq cleared", h_irq, 0);

    // R4 full and overflow
    for (int i = 0; i < 8; i++) hw(4'h0, 32'h100 + i);
    hw(4'h0, 32'hDEAD);
    hr(4'h4, r); check(r == 32'h080C_0429, "R4 full stat", r, 32'h080C_0429);
    check((r[31:24] - (r[23:16] - r[15:8])) == 0, "R3 free zero", r, 32'h080C_0429);
    for (int i = 0; i < 8; i++) begin
      er(4'h8, r); check(r == 32'h100 + i, "R4 order after drop", r, 32'h100 + i);
    end
    er(4'h8, r); check(r == 0, "R5 empty after full", r, 0);
    hr(4'h4, r); check(r[5] == 1'b1, "R4 overflow sticky", r, 32'h080C_0C29);
    hw(4'h4, 32'h29);
    hr(4'h4, r); check(r == 32'h080C_0C09, "R4 overflow cleared", r, 32'h080C_0C09);

    // R3 wrap: run offsets to 254, then push across 255
    for (int i = 0; i < 242; i++) begin
      hw(4'h0, 32'hA000 + i);
      er(4'h8, r);
      if (r != 32'hA000 + i) check(0, "R3 wrap data", r, 32'hA000 + i);
    end
    check(1, "R3 wrap loop", 0, 0);
    for (int i = 0; i < 3; i++) hw(4'h0, 32'hB0 + i);
    hr(4'h4, r); check(r == 32'h0801_FE09, "R3 wrapped offsets", r, 32'h0801_FE09);
    check(8'(r[23:16] - r[15:8]) == 8'd3, "R3 fill across wrap", r, 3);
    for (int i = 0; i < 3; i++) begin
      er(4'h8, r); check(r == 32'hB0 + i, "R3 data across wrap", r, 32'hB0 + i);
    end

    // R8 ready gating
    hw(4'h4, 32'h01);
    hw(4'h0, 32'h77);
    er(4'hC, r); check(r == 32'h0801_0109, "R8 push dropped", r, 32'h0801_0109);
    hr(4'h4, r); check(r == 32'h0801_0101, "R8 no overflow", r, 32'h0801_0101);
    hw(4'h4, 32'h09);
    hw(4'h0, 32'h88);
    hw(4'h4, 32'h01);
    er(4'h8, r); check(r == 0, "R8 pop blocked", r, 0);
    er(4'hC, r); check(r == 32'h0802_0109, "R8 rd unchanged", r, 32'h0802_0109);
    hw(4'h4, 32'h09);
    er(4'h8, r); check(r == 32'h88, "R8 pop after ready", r, 32'h88);

    // R9 reset request
    hw(4'h0, 32'h99);
    hw(4'h4, 32'h19);
    idle(2);
    er(4'hC, r); check(r == 32'h0800_0001, "R9 cleared", r, 32'h0800_0001);
    ew(4'hC, 32'h09);
    er(4'hC, r); check(r == 32'h0800_0001, "R9 ready held low", r, 32'h0800_0001);
    hr(4'h4, r); check(r == 32'h0800_0019 - 32'h8, "R9 host stat", r, 32'h0800_0011);
    hw(4'h4, 32'h09);
    hr(4'h4, r); check(r == 32'h0800_0009, "R9 host released", r, 32'h0800_0009);
    ew(4'hC, 32'h09);
    er(4'hC, r); check(r == 32'h0800_0009, "R9 engine ready", r, 32'h0800_0009);
    hw(4'h0, 32'h5A);
    er(4'h8, r); check(r == 32'h5A, "R9 transfer after release", r, 32'h5A);

    // R10 reset mid-run
    hw(4'h0, 32'h66);
    @(negedge clk) rst_n = 0;
    idle(2);
    @(negedge clk) rst_n = 1;
    check(h_irq == 0 && e_irq == 0, "R10 irq after reset", {h_irq, e_irq}, 0);
    hr(4'h4, r); check(r == 32'h0800_0000, "R10 stat after reset", r, 32'h0800_0000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule